// File: doc/BRIEF.md
# Programmable Raster Timing Generator for Parallel TFT Panels

This block produces the scan timing for a parallel TFT panel. It steps a horizontal and a vertical position counter on a pixel-tick enable that an external clock divider supplies. From these counters it derives the sync pulses, a data-enable flag, and the active-area pixel coordinates that a pixel fetch stage uses. The line layout and the frame layout come from three packed configuration words.

The horizontal lengths are coded as cycles minus one. The vertical porches are coded as plain line counts. The active width is set in steps of 16 pixels. A fourth word sets the polarity of each sync and of the pixel clock. It also selects which pixel-clock edge launches the syncs.

Scanning starts at the top of a frame once the enable input is high. When the enable drops, the frame in progress runs to its end and the block then goes idle.

Top module: `lcd_raster_timer`

## Requirements
- R1: A line is built from four segments in order: sync, back porch, active, front porch. Their lengths in pixel ticks are h_timing[9:0]+1, h_timing[19:10]+1, the active width, and h_timing[29:20]+1. The raw hsync is high during the sync segment.
- R2: A frame is built from four segments of whole lines in order: sync, back porch, active, front porch. Their lengths are v_timing[5:0]+1, v_timing[13:6], frame_size[17:7]+1, and v_timing[21:14]. Either porch may be zero. The raw vsync is high for every tick of the sync lines.
- R3: The active width is (frame_size[6:0]+1)*16 pixels. px counts 0 upward across the active pixels of a line, and py counts active lines from 0. Both read 0 whenever de is low.
- R4: de is high only for a tick that lies in the horizontal active segment and in an active line.
- R5: sig_ctl[0] inverts hsync, sig_ctl[1] inverts vsync and sig_ctl[2] inverts pix_clk, each on its own. Uninverted, pix_clk is high for the single clock cycle that follows each pixel tick.
- R6: When sig_ctl[3] and sig_ctl[4] are both 1, hsync and vsync change on the rising pixel-clock edge, together with the other outputs. In every other setting they change one clock cycle later, on the falling edge. sig_ctl[4] has no effect while sig_ctl[3] is 0.
- R7: While idle, the block emits inactive outputs. Once scan_en is high, the next pixel tick emits the first pixel of the first sync line.
- R8: When scan_en is low at the last tick of a frame, scanning stops after that tick and the outputs return to idle. scan_done pulses for one clock cycle, in the same cycle as that frame's frame_end.
- R9: frame_end is a one-cycle pulse that comes with the last tick of the final line of each frame. That line is the last front-porch line, or the last active line when the front porch is zero.
- R10: line_end is a one-cycle pulse that comes with the last tick of every line.
- R11: All outputs except the sync launch delay update only on a pixel tick. Between ticks, de, px and py hold, and the pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_tick | input | 1 | Pixel-clock enable from the external divider |
| scan_en | input | 1 | Raster enable |
| h_timing | input | 30 | Horizontal sync, back porch and front porch, each as length minus one |
| v_timing | input | 22 | Vertical sync as length minus one; vertical back porch and front porch as line counts |
| frame_size | input | 18 | Active width in units of 16 pixels, minus one; active lines minus one |
| sig_ctl | input | 5 | Polarity inverts and sync-edge select |
| pix_clk | output | 1 | Pixel clock, with selectable polarity |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px | output | 11 | Active pixel column |
| py | output | 11 | Active line number |
| line_end | output | 1 | Last tick of a line |
| frame_end | output | 1 | Last tick of a frame |
| scan_done | output | 1 | Scanning stopped after this frame |

## Verification
Three events can land in the same cycle: the end of a line, the end of a frame, and the stop of scanning. The stop request is sampled exactly at the frame boundary, so these three pulses share one clock.

The bench provokes this in two ways. In one run it drops scan_en during the tick just before the last tick of a frame. In another it drops scan_en early in the final frame. In both cases the scoreboard expects line_end, frame_end and scan_done together on that final tick, and idle outputs on every tick afterwards.

An off-by-one in the stop sampling would show up in one of two ways: either a further frame appears, or the pulse lands one tick early.

// File: rtl/lcd_rt_pkg.sv
package lcd_rt_pkg;
   localparam int HF_W  = 10;
   localparam int VP_W  = 8;
   localparam int VS_W  = 6;
   localparam int PPL_W = 7;
   localparam int LPP_W = 11;

   typedef struct packed {
      logic [HF_W-1:0] front_m1;
      logic [HF_W-1:0] back_m1;
      logic [HF_W-1:0] sync_m1;
   } h_cfg_t;

   typedef struct packed {
      logic [VP_W-1:0] front;
      logic [VP_W-1:0] back;
      logic [VS_W-1:0] sync_m1;
   } v_cfg_t;

   typedef struct packed {
      logic [LPP_W-1:0] lines_m1;
      logic [PPL_W-1:0] width16_m1;
   } size_cfg_t;

   typedef struct packed {
      logic launch_rise;
      logic launch_sel_en;
      logic inv_pclk;
      logic inv_vsync;
      logic inv_hsync;
   } pol_cfg_t;

   localparam int INV_PCLK_BIT = 2;
endpackage

// File: rtl/lcd_rt_axis.sv
module lcd_rt_axis #(
   parameter int POS_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [POS_W-1:0] len_sync,
   input  logic [POS_W-1:0] len_back,
   input  logic [POS_W-1:0] len_act,
   input  logic [POS_W-1:0] len_front,
   output logic [POS_W-1:0] idx,
   output logic             last,
   output logic             in_sync,
   output logic             in_act
);
   logic [POS_W-1:0] pos, act_lo, act_hi, total_m1;

   always_comb begin
      act_lo   = len_sync + len_back;
      act_hi   = act_lo + len_act;
      total_m1 = act_hi + len_front - POS_W'(1);
      last     = (pos >= total_m1);
      in_sync  = (pos < len_sync);
      in_act   = (pos >= act_lo) && (pos < act_hi);
      idx      = in_act ? (pos - act_lo) : '0;
   end

   // position counter; wraps at the programmed total (also recovers if it overshoots)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pos <= '0;
      else if (step)  pos <= last ? '0 : pos + POS_W'(1);
   end
endmodule

// File: rtl/lcd_rt_launch.sv
module lcd_rt_launch #(
   parameter bit SEL_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_in,
   input  logic vs_in,
   input  logic ctl_en,
   input  logic rise_sel,
   input  logic inv_hs,
   input  logic inv_vs,
   output logic hs_out,
   output logic vs_out
);
   logic hs_d, vs_d;

   // one-clock delay: sync launched on the falling pixel-clock edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_d <= 1'b0;
         vs_d <= 1'b0;
      end else begin
         hs_d <= hs_in;
         vs_d <= vs_in;
      end
   end

   generate
      if (SEL_EN) begin : g_sel
         logic use_rise;
         assign use_rise = ctl_en & rise_sel;
         assign hs_out   = (use_rise ? hs_in : hs_d) ^ inv_hs;
         assign vs_out   = (use_rise ? vs_in : vs_d) ^ inv_vs;
      end else begin : g_fixed
         assign hs_out = hs_d ^ inv_hs;
         assign vs_out = vs_d ^ inv_vs;
      end
   endgenerate
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
   import lcd_rt_pkg::*;
#(
   parameter int H_POS_W       = 13,
   parameter int V_POS_W       = 12,
   parameter int X_W           = 11,
   parameter int Y_W           = 11,
   parameter bit SEL_LAUNCH_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pix_tick,
   input  logic                        scan_en,
   input  logic [$bits(h_cfg_t)-1:0]    h_timing,
   input  logic [$bits(v_cfg_t)-1:0]    v_timing,
   input  logic [$bits(size_cfg_t)-1:0] frame_size,
   input  logic [$bits(pol_cfg_t)-1:0]  sig_ctl,
   output logic                        pix_clk,
   output logic                        hsync,
   output logic                        vsync,
   output logic                        de,
   output logic [X_W-1:0]              px,
   output logic [Y_W-1:0]              py,
   output logic                        line_end,
   output logic                        frame_end,
   output logic                        scan_done
);
   localparam int H_NEED = 13;   // 3 x 1024 + 2048 ticks per line
   localparam int V_NEED = 12;   // 64 + 255 + 2048 + 255 lines per frame

   generate
      if (H_POS_W < H_NEED) begin : g_bad_hw
         $error("H_POS_W too narrow for the longest line");
      end
      if (V_POS_W < V_NEED) begin : g_bad_vw
         $error("V_POS_W too narrow for the tallest frame");
      end
      if (X_W < PPL_W + 4 || Y_W < LPP_W) begin : g_bad_xy
         $error("coordinate width too narrow");
      end
   endgenerate

   h_cfg_t    hc;
   v_cfg_t    vc;
   size_cfg_t fs;
   pol_cfg_t  pc;
   assign hc = h_cfg_t'(h_timing);
   assign vc = v_cfg_t'(v_timing);
   assign fs = size_cfg_t'(frame_size);
   assign pc = pol_cfg_t'(sig_ctl);

   logic               scanning, go, h_step, v_step, frame_wrap;
   logic [H_POS_W-1:0] h_idx;
   logic [V_POS_W-1:0] v_idx;
   logic               h_last, h_sync, h_act, v_last, v_sync, v_act;
   logic               hs_raw, vs_raw, pclk_q;

   assign go         = scanning | scan_en;
   assign h_step     = pix_tick & go;
   assign v_step     = h_step & h_last;
   assign frame_wrap = v_step & v_last;

   lcd_rt_axis #(.POS_W(H_POS_W)) u_h_axis (
      .clk(clk), .rst_n(rst_n), .step(h_step),
      .len_sync (H_POS_W'(hc.sync_m1)  + H_POS_W'(1)),
      .len_back (H_POS_W'(hc.back_m1)  + H_POS_W'(1)),
      .len_act  (H_POS_W'({fs.width16_m1, 4'hF}) + H_POS_W'(1)),
      .len_front(H_POS_W'(hc.front_m1) + H_POS_W'(1)),
      .idx(h_idx), .last(h_last), .in_sync(h_sync), .in_act(h_act)
   );

   lcd_rt_axis #(.POS_W(V_POS_W)) u_v_axis (
      .clk(clk), .rst_n(rst_n), .step(v_step),
      .len_sync (V_POS_W'(vc.sync_m1) + V_POS_W'(1)),
      .len_back (V_POS_W'(vc.back)),
      .len_act  (V_POS_W'(fs.lines_m1) + V_POS_W'(1)),
      .len_front(V_POS_W'(vc.front)),
      .idx(v_idx), .last(v_last), .in_sync(v_sync), .in_act(v_act)
   );

   // scanning continues until a frame boundary sees the enable low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       scanning <= 1'b0;
      else if (h_step)  scanning <= frame_wrap ? scan_en : 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_raw <= 1'b0; vs_raw <= 1'b0; de <= 1'b0;
         px <= '0; py <= '0;
         line_end <= 1'b0; frame_end <= 1'b0; scan_done <= 1'b0;
      end else if (pix_tick && go) begin
         hs_raw    <= h_sync;
         vs_raw    <= v_sync;
         de        <= h_act & v_act;
         px        <= (h_act & v_act) ? X_W'(h_idx) : '0;
         py        <= (h_act & v_act) ? Y_W'(v_idx) : '0;
         line_end  <= h_last;
         frame_end <= frame_wrap;
         scan_done <= frame_wrap & ~scan_en;
      end else if (pix_tick) begin
         hs_raw <= 1'b0; vs_raw <= 1'b0; de <= 1'b0;
         px <= '0; py <= '0;
         line_end <= 1'b0; frame_end <= 1'b0; scan_done <= 1'b0;
      end else begin
         line_end <= 1'b0; frame_end <= 1'b0; scan_done <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pclk_q <= 1'b0;
      else        pclk_q <= pix_tick;
   end
   assign pix_clk = pclk_q ^ pc.inv_pclk;

   lcd_rt_launch #(.SEL_EN(SEL_LAUNCH_EN)) u_launch (
      .clk(clk), .rst_n(rst_n), .hs_in(hs_raw), .vs_in(vs_raw),
      .ctl_en(pc.launch_sel_en), .rise_sel(pc.launch_rise),
      .inv_hs(pc.inv_hsync), .inv_vs(pc.inv_vsync),
      .hs_out(hsync), .vs_out(vsync)
   );
endmodule

// File: rtl/lcd_rt_chk.sv
module lcd_rt_chk #(
   parameter int X_W = 11,
   parameter int Y_W = 11
) (
   input logic           clk,
   input logic           rst_n,
   input logic           pix_tick,
   input logic           scan_en,
   input logic           inv_pclk,
   input logic           pix_clk,
   input logic           de,
   input logic [X_W-1:0] px,
   input logic [Y_W-1:0] py,
   input logic           line_end,
   input logic           frame_end,
   input logic           scan_done
);
   p_frame_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !frame_end);

   p_stop_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> frame_end);

   p_stop_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> $past(!scan_en));

   p_frame_on_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> line_end);

   p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_tick |=> ($stable(de) && $stable(px) && $stable(py)));

   p_coord_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> (px == '0 && py == '0));

   p_pclk_follows_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_tick |=> (pix_clk != inv_pclk));
endmodule

bind lcd_raster_timer lcd_rt_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .scan_en(scan_en),
   .inv_pclk(sig_ctl[lcd_rt_pkg::INV_PCLK_BIT]), .pix_clk(pix_clk),
   .de(de), .px(px), .py(py), .line_end(line_end),
   .frame_end(frame_end), .scan_done(scan_done)
);

// File: tb/tb_lcd_raster_timer.sv
module tb_lcd_raster_timer;
   localparam int DIV = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_tick = 1'b0;
   logic        scan_en = 1'b0;
   logic [29:0] h_timing = '0;
   logic [21:0] v_timing = '0;
   logic [17:0] frame_size = '0;
   logic [4:0]  sig_ctl = '0;
   logic        pix_clk, hsync, vsync, de, line_end, frame_end, scan_done;
   logic [10:0] px, py;

   lcd_raster_timer dut (
      .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .scan_en(scan_en),
      .h_timing(h_timing), .v_timing(v_timing), .frame_size(frame_size),
      .sig_ctl(sig_ctl), .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync),
      .de(de), .px(px), .py(py), .line_end(line_end),
      .frame_end(frame_end), .scan_done(scan_done)
   );

   always #5 clk = ~clk;

   typedef struct packed {
      logic de, hs, vs, le, fe, rd;
      logic [10:0] x, y;
   } exp_t;

   exp_t q[$];
   int n_tot = 0, n_bad = 0;
   bit finished = 1'b0;

   // configuration mirror used by the model
   int hsw, hbp, hfp, w16, vsw, vbp, lines, vfp;
   bit inv_hs, inv_vs, inv_pc, sel_en, rise;

   task automatic chk(bit ok, string tag, int act, int exp);
      n_tot++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic apply_cfg();
      h_timing   = {10'(hfp), 10'(hbp), 10'(hsw)};
      v_timing   = {8'(vfp), 8'(vbp), 6'(vsw)};
      frame_size = {11'(lines), 7'(w16)};
      sig_ctl    = {rise, sel_en, inv_pc, inv_vs, inv_hs};
   endtask

   function automatic int frame_ticks();
      return ((hsw + 1) + (hbp + 1) + (w16 + 1) * 16 + (hfp + 1)) *
             ((vsw + 1) + vbp + (lines + 1) + vfp);
   endfunction

   // driver side of the scoreboard: expected item for every emitted tick
   task automatic push_frames(int nfr);
      int hs_l = hsw + 1, hb_l = hbp + 1, aw = (w16 + 1) * 16, hf_l = hfp + 1;
      int vs_l = vsw + 1, al = lines + 1;
      int ht = hs_l + hb_l + aw + hf_l;
      int vt = vs_l + vbp + al + vfp;
      for (int f = 0; f < nfr; f++)
         for (int l = 0; l < vt; l++)
            for (int p = 0; p < ht; p++) begin
               exp_t e;
               bit ah = (p >= hs_l + hb_l) && (p < hs_l + hb_l + aw);
               bit av = (l >= vs_l + vbp) && (l < vs_l + vbp + al);
               e.hs = (p < hs_l);
               e.vs = (l < vs_l);
               e.de = ah && av;
               e.x  = e.de ? 11'(p - hs_l - hb_l) : 11'd0;
               e.y  = e.de ? 11'(l - vs_l - vbp) : 11'd0;
               e.le = (p == ht - 1);
               e.fe = e.le && (l == vt - 1);
               e.rd = e.fe && (f == nfr - 1);
               q.push_back(e);
            end
   endtask

   task automatic run_frames(int nfr, int stop_after);
      @(posedge clk iff pix_tick);
      @(negedge clk);
      scan_en = 1'b1;            // R7: next tick emits the top of the frame
      push_frames(nfr);
      repeat (stop_after) @(posedge clk iff pix_tick);
      @(negedge clk);
      scan_en = 1'b0;            // R8: current frame must still complete
      wait (q.size() == 0);
      repeat (4) @(posedge clk iff pix_tick);
      @(negedge clk);
   endtask

   // pixel-tick divider
   initial begin
      int dcnt = 0;
      forever begin
         @(negedge clk);
         dcnt = (dcnt + 1) % DIV;
         pix_tick = (dcnt == 0);
      end
   end

   // monitor side of the scoreboard
   initial begin
      bit prev_hs = 1'b0, prev_vs = 1'b0;
      wait (rst_n);
      forever begin
         exp_t e;
         bit fall;
         logic s_de;
         logic [10:0] s_x, s_y;
         @(posedge clk iff pix_tick);
         #2;
         e = (q.size() != 0) ? q.pop_front() : exp_t'(0);
         fall = !(sel_en && rise);
         chk(de == e.de, "R4 de", de, e.de);
         chk(px == e.x, "R3 px", px, e.x);
         chk(py == e.y, "R3 py", py, e.y);
         chk(line_end == e.le, "R10 line_end", line_end, e.le);
         chk(frame_end == e.fe, "R9 frame_end", frame_end, e.fe);
         chk(scan_done == e.rd, "R8 scan_done", scan_done, e.rd);
         chk(pix_clk == (1'b1 ^ inv_pc), "R5 pix_clk on tick", pix_clk, 1 ^ inv_pc);
         if (fall) begin
            chk(hsync == (prev_hs ^ inv_hs), "R6 hsync not yet launched", hsync, prev_hs ^ inv_hs);
            chk(vsync == (prev_vs ^ inv_vs), "R6 vsync not yet launched", vsync, prev_vs ^ inv_vs);
         end else begin
            chk(hsync == (e.hs ^ inv_hs), "R1 hsync", hsync, e.hs ^ inv_hs);
            chk(vsync == (e.vs ^ inv_vs), "R2 vsync", vsync, e.vs ^ inv_vs);
         end
         s_de = de; s_x = px; s_y = py;
         #10;
         chk(de == s_de && px == s_x && py == s_y, "R11 hold between ticks", {de, px}, {s_de, s_x});
         chk(!line_end && !frame_end && !scan_done, "R9 pulses one clock", {line_end, frame_end, scan_done}, 0);
         chk(pix_clk == inv_pc, "R5 pix_clk off tick", pix_clk, inv_pc);
         chk(hsync == (e.hs ^ inv_hs), "R1 R6 hsync launched", hsync, e.hs ^ inv_hs);
         chk(vsync == (e.vs ^ inv_vs), "R2 R6 vsync launched", vsync, e.vs ^ inv_vs);
         prev_hs = e.hs;
         prev_vs = e.vs;
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_tot++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
         $finish;
      end
   end

   initial begin
      // config A: rising launch, no inversion, vfp = 0
      hsw = 1; hbp = 0; hfp = 1; w16 = 0;
      vsw = 0; vbp = 1; lines = 2; vfp = 0;
      inv_hs = 0; inv_vs = 0; inv_pc = 0; sel_en = 1; rise = 1;
      apply_cfg();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R7 idle)
      chk(de == 0 && px == 0 && py == 0, "R7 reset de/px/py", {de, px, py}, 0);
      chk(!frame_end && !line_end && !scan_done, "R7 reset pulses", {frame_end, line_end, scan_done}, 0);
      chk(hsync == 0 && vsync == 0, "R7 reset syncs", {hsync, vsync}, 0);
      repeat (3) @(posedge clk iff pix_tick);
      // two frames, stop early in the second
      run_frames(2, frame_ticks() + 3);

      // config B: falling launch, hsync and pixel clock inverted, vbp = 0
      hsw = 0; hbp = 2; hfp = 0; w16 = 1;
      vsw = 1; vbp = 0; lines = 1; vfp = 2;
      inv_hs = 1; inv_vs = 0; inv_pc = 1; sel_en = 1; rise = 0;
      apply_cfg();
      repeat (3) @(posedge clk iff pix_tick);
      @(negedge clk);
      run_frames(1, 5);

      // config C: select bit ignored while sel_en = 0; stop on last tick of frame
      hsw = 2; hbp = 1; hfp = 0; w16 = 0;
      vsw = 0; vbp = 2; lines = 0; vfp = 1;
      inv_hs = 0; inv_vs = 1; inv_pc = 0; sel_en = 0; rise = 1;
      apply_cfg();
      repeat (3) @(posedge clk iff pix_tick);
      @(negedge clk);
      run_frames(2, 2 * frame_ticks() - 1);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   end
endmodule